// File: doc/BRIEF.md
# Latched 40-bit Timestamp Counter

This block keeps a 40-bit free-running count that serves as a system time base. It advances by one on every clock cycle in which an external tick strobe is high and its own run bit is set. The strobe normally arrives at about 983.04 kHz. When the count passes its all-ones value it wraps to zero. It raises no interrupt and no flag.

Software reaches the count through a simple 32-bit register port. A read of the low word at offset 0x60 returns count bits 31:0. In the same cycle it copies count bits 39:32 into a shadow byte. A later read of the high register at offset 0x64 returns that shadow byte, not the live upper byte. A 40-bit value assembled from a low read followed by a high read is therefore consistent, even if the counter carried into its upper byte between the two reads. Bit 8 of the high register is the run bit, and software can write it. Read data is registered and appears one cycle after the read strobe, qualified by a valid pulse.

Top module: `tstamp_ctr40`

## Requirements
- R1: After reset the count, the shadow byte and the run bit are all zero, so a low read and a high read both return 0x00000000.
- R2: The count rises by exactly one in each cycle in which both `tick_en` and the run bit are high. It holds its value in every other cycle.
- R3: A read asserted in cycle t produces `bus_rvalid` high in cycle t+1, with no valid pulse otherwise. A low-word read (address 0x60) returns count bits 31:0 as they stood in cycle t, before any increment in that cycle.
- R4: A low-word read captures count bits 39:32 into the shadow byte in the same cycle. A later high read returns that captured byte even if the live upper byte has changed since.
- R5: A high read (address 0x64) returns the shadow byte in bits 7:0, the run bit in bit 8, and zero in bits 31:9.
- R6: A write to address 0x64 loads the run bit from write-data bit 8 and ignores all other write-data bits. A write to any other address, including the low word, changes nothing.
- R7: From the all-ones value the count wraps to zero on the next counted tick.
- R8: A high read leaves the shadow byte unchanged. A read of any unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe, one count per high cycle while running |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds a read result |

## Verification
Each fault class shows up at the ports within two cycles:
- A count that skips or sticks gives a wrong low word on the next low read.
- A shadow byte that is refreshed at the wrong time differs from the byte captured earlier only on a high read that follows a carry into bit 32.
- Because of that, a second instance starts just below the wrap point. The carry and the wrap are then exercised within a few ticks.
- A run bit that is lost or set by a stray write shows in bit 8 of the next high read. It also shows as a frozen or moving low word.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tstamp_count.sv
module tstamp_count #(
  parameter int CNT_W = 40,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Free-running up-counter; natural binary wrap, no carry-out flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CNT_RST;
    end else if (run && tick) begin
      count <= count + ONE;
    end
  end
endmodule

// File: rtl/tstamp_snap.sv
module tstamp_snap #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [HI_W-1:0] upper,
  output logic [HI_W-1:0] shadow
);
  // Holds the upper count bits seen at the last low-word read.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (capture) begin
      shadow <= upper;
    end
  end
endmodule

// File: rtl/tstamp_regs.sv
module tstamp_regs
  import tstamp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HI_W   = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(8'h60),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(8'h64)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  word_t             count_lo,
  input  logic [HI_W-1:0]   shadow,
  output logic              capture,
  output logic              run_en,
  output word_t             rdata,
  output logic              rvalid
);
  localparam int EN_BIT = HI_W;

  logic  sel_lo, sel_hi;
  word_t hi_word, rd_mux;
  logic  unused_wbits;

  assign sel_lo  = (addr == LO_ADDR);
  assign sel_hi  = (addr == HI_ADDR);
  assign capture = rd && sel_lo;
  assign unused_wbits = ^{wdata[WORD_W-1:EN_BIT+1], wdata[EN_BIT-1:0]};

  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = shadow;
    hi_word[EN_BIT]     = run_en;
  end

  always_comb begin
    if (sel_lo)      rd_mux = count_lo;
    else if (sel_hi) rd_mux = hi_word;
    else             rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en <= 1'b0;
    end else if (wr && sel_hi) begin
      run_en <= wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tstamp_ctr40.sv
module tstamp_ctr40
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(8'h60),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(8'h64),
  parameter logic [CNT_W-1:0]  CNT_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int HI_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;
  logic             run_en_q;
  logic             cap;

  tstamp_count #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_count (
    .clk   (clk),
    .rst   (rst),
    .run   (run_en_q),
    .tick  (tick_en),
    .count (cnt_q)
  );

  tstamp_snap #(.HI_W(HI_W)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .capture (cap),
    .upper   (cnt_q[CNT_W-1:WORD_W]),
    .shadow  (shadow_q)
  );

  tstamp_regs #(
    .ADDR_W(ADDR_W), .HI_W(HI_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .count_lo (cnt_q[WORD_W-1:0]),
    .shadow   (shadow_q),
    .capture  (cap),
    .run_en   (run_en_q),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );
endmodule

// File: rtl/tstamp_ctr40_chk.sv
module tstamp_ctr40_chk #(
  parameter int CNT_W  = 40,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(8'h60),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(8'h64)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-33:0] shadow,
  input logic              run_en
);
  localparam int HI_W = CNT_W - 32;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_en && tick_en) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(run_en && tick_en) |=> $stable(cnt)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (run_en && tick_en && (&cnt)) |=> (cnt == '0)); // R7
  AST_RVALID_ON_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R3
  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R3
  AST_LO_DATA: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == LO_ADDR) |=> (bus_rdata == $past(cnt[31:0]))); // R3
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == LO_ADDR) |=> (shadow == $past(cnt[CNT_W-1:32]))); // R4
  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_addr == LO_ADDR) |=> $stable(shadow)); // R8
  AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == HI_ADDR) |=> (bus_rdata[31:HI_W+1] == '0)); // R5
  AST_RUN_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == HI_ADDR) |=> $stable(run_en)); // R6
endmodule

bind tstamp_ctr40 tstamp_ctr40_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_en    (tick_en),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .cnt        (cnt_q),
  .shadow     (shadow_q),
  .run_en     (run_en_q)
);

// File: tb/tstamp_ctr40_test.sv
module tstamp_ctr40_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LO = 8'h60;
  localparam logic [7:0] A_HI = 8'h64;
  localparam logic [39:0] WRAP_START = 40'hFF_FFFF_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_m, rdata_w;
  logic        rvalid_m, rvalid_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp_m;
    logic [31:0] exp_w;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // Reference model state: [0] main instance, [1] near-wrap instance
  logic [39:0] m_cnt [2];
  logic [7:0]  m_sh  [2];
  logic        m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_ctr40 uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_m), .bus_rvalid(rvalid_m)
  );

  tstamp_ctr40 #(.CNT_RST(WRAP_START)) uut_wrap (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_w), .bus_rvalid(rvalid_w)
  );

  function automatic logic [31:0] model_read(input int k, input logic [7:0] a);
    if (a == A_LO)      return m_cnt[k][31:0];
    else if (a == A_HI) return {23'b0, m_en, m_sh[k]};
    else                return 32'h0;
  endfunction

  // Driver: applies one cycle of stimulus and advances the model.
  task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                      input logic [31:0] d, input logic tk, input string tag);
    exp_t e;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    if (rd) begin
      e.exp_m = model_read(0, a);
      e.exp_w = model_read(1, a);
      e.tag   = tag;
      sb_q.push_back(e);
    end
    for (int k = 0; k < 2; k++) begin
      if (rd && a == A_LO) m_sh[k] = m_cnt[k][39:32];
      if (m_en && tk) m_cnt[k] = m_cnt[k] + 40'd1;
    end
    if (wr && a == A_HI) m_en = d[8];
  endtask

  task automatic ticks(input int n, input logic tk);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0, tk, "");
  endtask

  // Monitor: pops expected results as read data comes back.
  always @(negedge clk) begin
    if (!rst) begin
      if (rvalid_m != rvalid_w) begin
        checks++; errors++;
        $display("FAIL R3: valid mismatch between instances act=%b/%b exp=equal",
                 rvalid_m, rvalid_w);
      end
      if (rvalid_m) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3: valid with no read act=1 exp=0");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          checks++;
          if (rdata_m !== e.exp_m) begin
            errors++;
            $display("FAIL %s: main act=%h exp=%h", e.tag, rdata_m, e.exp_m);
          end
          checks++;
          if (rdata_w !== e.exp_w) begin
            errors++;
            $display("FAIL %s: wrap act=%h exp=%h", e.tag, rdata_w, e.exp_w);
          end
        end
      end
    end
  end

  initial begin
    m_cnt[0] = '0; m_cnt[1] = WRAP_START;
    m_sh[0] = '0;  m_sh[1] = '0;
    m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    step(1, 0, A_LO, 0, 0, "R1");
    step(1, 0, A_HI, 0, 0, "R1");
    step(0, 1, A_HI, 32'hABCD_01FF, 0, "R6");
    step(1, 0, A_HI, 0, 0, "R5");
    ticks(5, 1'b1);
    ticks(3, 1'b0);
    step(1, 0, A_LO, 0, 0, "R2");
    step(1, 0, A_LO, 0, 1, "R3");
    ticks(3, 1'b1);
    step(1, 0, A_HI, 0, 0, "R4");
    ticks(10, 1'b1);
    step(1, 0, A_HI, 0, 1, "R4");
    step(1, 0, A_HI, 0, 0, "R8");
    step(1, 0, A_LO, 0, 0, "R7");
    step(1, 0, A_HI, 0, 0, "R4");
    step(0, 1, A_HI, 32'hFFFF_FEFF, 1, "R6");
    ticks(4, 1'b1);
    step(1, 0, A_LO, 0, 0, "R2");
    step(0, 1, A_LO, 32'hFFFF_FFFF, 1, "R6");
    step(1, 0, A_LO, 0, 0, "R6");
    step(1, 0, A_HI, 0, 0, "R5");
    step(1, 0, 8'h68, 0, 0, "R8");
    step(0, 1, A_HI, 32'h0000_0100, 0, "R6");
    ticks(2, 1'b1);
    step(1, 0, A_LO, 0, 1, "R2");
    step(1, 0, A_HI, 0, 0, "R5");
    ticks(4, 1'b0);

    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R3: reads without result act=%0d exp=0", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule